// File: doc/BRIEF.md
# Circular Return-Address Stack

This block keeps subroutine and interrupt return addresses for a small processor core. The core pulses a push strobe when it takes a call or acknowledges an interrupt, which stores the current program counter. It pulses a pop strobe on any of its return instructions, which hands back the most recently stored address in that same cycle. The stack pointer is internal. Nothing outside the block can read it or load it.

The storage wraps in both directions and never refuses an operation. Pushing past the last slot overwrites the oldest addresses. Popping below slot 0 continues from the last slot. A single status output, `avail_o`, tells software whether there is headroom. It drops while the pointer sits on the last slot. It becomes permanently low once a push carries the pointer from the last slot back to zero, and only a reset releases it. The block has no separate underflow flag. A pop issued straight after reset lands on the last slot and looks exactly like a full stack.

Top module: `retstack`

## Requirements
- R1: After an active-low reset the pointer is 0, every entry reads 0 and `avail_o` is 1. A pop issued immediately after reset returns 16'h0000.
- R2: A push alone writes `push_data_i` at the pointer and then advances the pointer by one, modulo 16. A pop alone steps the pointer back by one, modulo 16, and drives the entry at that new position on `pop_data_o` combinationally, in the cycle the pop strobe is high. Pops therefore return pushed values in last-in, first-out order.
- R3: `avail_o` is 0 whenever the pointer equals 15. After 14 pushes from reset it is still 1, and after 15 pushes it is 0.
- R4: A push alone with the pointer at 15 moves the pointer to 0 and locks `avail_o` at 0. It stays 0 through any later pushes, pops or simultaneous operations until the next reset.
- R5: Overflow overwrites the oldest entries. After 17 pushes d0..d16 from reset, 16 pops return d16, d15, ..., d1 in that order, and a 17th pop returns d16 again.
- R6: A pop that moves the pointer from 0 to 15 does not lock the flag. From reset, one pop drives `avail_o` to 0 and a second pop brings it back to 1. A push that follows the first pop, with no other pop between, moves the pointer to 0 and locks the flag as in R4.
- R7: When push and pop are high in the same cycle, `pop_data_o` shows the current top entry and `push_data_i` replaces it (written at pointer minus one). The pointer does not change.
- R8: A simultaneous push and pop never sets the lock, even with the pointer at 15. A following pop alone brings `avail_o` back to 1.
- R9: A reset after the flag has locked restores the R1 state. Fifteen pushes after it then make `avail_o` 0, and one pop makes it 1 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| push_i | input | 1 | Single-cycle strobe that stores `push_data_i` |
| pop_i | input | 1 | Single-cycle strobe that removes the top entry |
| push_data_i | input | 16 | Return address to store |
| pop_data_o | output | 16 | Top entry, valid in the cycle `pop_i` is high |
| avail_o | output | 1 | Stack-available status; 0 means full, overflowed or underflowed |

## Verification
The bench targets the following corner cases, each paired with the wrong behaviour it would catch:
- The 17th push. A design that saturated the pointer instead of wrapping it would return d15 first rather than d16 after a wrap.
- A pop straight after reset followed by a push. A design that latched the lock on the downward wrap would keep `avail_o` low after a second pop. A design that ignored the upward wrap would raise it again after the push.
- A simultaneous push and pop, both mid-stack and on the last slot. A design that moved the pointer or wrote at the pointer itself would return a stale or shifted value on the next pop. A design that set the lock on that last-slot case would never see `avail_o` recover.
- Reset after a lock. A design whose lock survived reset would show `avail_o` stuck low.

Random push and pop traffic, compared against a queue model on every pop and every cycle of `avail_o`, covers the wrapped orderings that the directed cases do not reach.

// File: rtl/retstack_pkg.sv
// Package: shared types for the return-address stack.
// Assumes push and pop strobes are sampled on the same clock edge.
package retstack_pkg;

    // Operation the stack performs in a given cycle.
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_PUSH = 2'b01,
        OP_POP  = 2'b10,
        OP_SWAP = 2'b11
    } stk_op_e;

    // Map the two strobes onto one operation code.
    function automatic stk_op_e classify(input logic push, input logic pop);
        stk_op_e op;
        case ({pop, push})
            2'b01:   op = OP_PUSH;
            2'b10:   op = OP_POP;
            2'b11:   op = OP_SWAP;
            default: op = OP_IDLE;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/retstack_ptr.sv
// Module: wrapping stack pointer.
// Advances on inc, steps back on dec, and holds otherwise. Both directions
// wrap modulo 2**AW. Assumes inc and dec are never high together, which the
// top guarantees by decoding a swap into neither.
module retstack_ptr #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [AW-1:0] ptr_q,
    output logic [AW-1:0] ptr_prev,
    output logic          at_last,
    output logic          wrap_up
);

    localparam logic [AW-1:0] LAST = {AW{1'b1}};
    localparam logic [AW-1:0] ONE  = {{(AW-1){1'b0}}, 1'b1};

    // Pointer register: reset to zero, then move by one in either direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (inc) begin
            ptr_q <= ptr_q + ONE;
        end else if (dec) begin
            ptr_q <= ptr_q - ONE;
        end
    end

    // Derived views of the pointer used by storage and status.
    always_comb begin
        ptr_prev = ptr_q - ONE;
        at_last  = (ptr_q == LAST);
        wrap_up  = inc && at_last;
    end

endmodule

// File: rtl/retstack_store.sv
// Module: register-file storage for the stack.
// One write port and one combinational read port. Every entry clears on
// reset so that reads before any write are defined.
module retstack_store #(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        localparam logic [AW-1:0] IDX = AW'(g);
        // Entry register: load when this slot is the write target.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (we && (waddr == IDX)) begin
                slot_q[g] <= wdata;
            end
        end
    end

    // Read port: asynchronous select of the addressed entry.
    always_comb begin
        rdata = slot_q[raddr];
    end

endmodule

// File: rtl/retstack_flag.sv
// Module: stack-available status.
// The status is low while the pointer is on the last slot. A push that wraps
// the pointer upward from the last slot sets a lock that holds the status low
// until reset.
module retstack_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_up,
    input  logic at_last,
    output logic lock_q,
    output logic avail
);

    // Lock register: set by an upward wrap, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else if (wrap_up) begin
            lock_q <= 1'b1;
        end
    end

    // Status output: headroom exists unless on the last slot or locked.
    always_comb begin
        avail = !at_last && !lock_q;
    end

endmodule

// File: rtl/retstack.sv
// Module: circular return-address stack, top level.
// Push stores push_data_i and advances. Pop steps back and shows that entry
// in the same cycle. Push with pop replaces the top entry in place. Assumes
// the strobes are single-cycle and synchronous to clk.
module retstack #(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [DW-1:0] push_data_i,
    output logic [DW-1:0] pop_data_o,
    output logic          avail_o
);

    import retstack_pkg::*;

    stk_op_e       op;
    logic          do_inc;
    logic          do_dec;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] ptr_prev;
    logic          at_last;
    logic          wrap_up;
    logic          lock_q;

    // Operation decode: choose pointer motion and write target.
    always_comb begin
        op      = classify(push_i, pop_i);
        do_inc  = (op == OP_PUSH);
        do_dec  = (op == OP_POP);
        wr_en   = (op == OP_PUSH) || (op == OP_SWAP);
        wr_addr = (op == OP_SWAP) ? ptr_prev : ptr_q;
    end

    retstack_ptr #(.AW(AW)) i_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (do_inc),
        .dec      (do_dec),
        .ptr_q    (ptr_q),
        .ptr_prev (ptr_prev),
        .at_last  (at_last),
        .wrap_up  (wrap_up)
    );

    retstack_store #(.AW(AW), .DW(DW)) i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (push_data_i),
        .raddr (ptr_prev),
        .rdata (pop_data_o)
    );

    retstack_flag i_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrap_up (wrap_up),
        .at_last (at_last),
        .lock_q  (lock_q),
        .avail   (avail_o)
    );

endmodule

// File: rtl/retstack_chk.sv
// Module: property checker for the return-address stack, bound to the top.
// Observes the strobes, the internal pointer and lock, and the status output.
module retstack_chk #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_i,
    input logic          pop_i,
    input logic [AW-1:0] ptr,
    input logic          lock,
    input logic          avail_o
);

    localparam logic [AW-1:0] LAST = {AW{1'b1}};

    p_reset_avail_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (avail_o && ptr == '0));

    p_push_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i) |=> (ptr == AW'($past(ptr) + 1'b1)));

    p_pop_retreat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> (ptr == AW'($past(ptr) - 1'b1)));

    p_last_slot_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr == LAST) |-> !avail_o);

    p_wrap_locks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && ptr == LAST) |=> (lock && !avail_o));

    p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> (lock && !avail_o));

    p_pop_wrap_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && ptr == '0 && !lock) |=> !lock);

    p_swap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> $stable(ptr));

    p_swap_no_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !lock) |=> !lock);

endmodule

bind retstack retstack_chk #(.AW(AW)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push_i),
    .pop_i   (pop_i),
    .ptr     (ptr_q),
    .lock    (lock_q),
    .avail_o (avail_o)
);

// File: tb/test_retstack.sv
module test_retstack;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_i = 1'b0;
    logic        pop_i = 1'b0;
    logic [15:0] push_data_i = '0;
    logic [15:0] pop_data_o;
    logic        avail_o;

    int total = 0;
    int bad = 0;

    // Reference model of the stack, built from the requirements.
    logic [15:0] mmem [16];
    logic [3:0]  mptr;
    logic        mlock;

    always #5 clk = ~clk;

    retstack i_retstack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push_i),
        .pop_i       (pop_i),
        .push_data_i (push_data_i),
        .pop_data_o  (pop_data_o),
        .avail_o     (avail_o)
    );

    function automatic logic exp_avail();
        return (mptr != 4'hF) && !mlock;
    endfunction

    function automatic logic [15:0] exp_top();
        return mmem[4'(mptr - 4'd1)];
    endfunction

    task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check1(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    // Reset: the cycle is entered and left at a falling edge.
    task automatic do_reset(input string tag);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) mmem[i] = '0;
        mptr = '0;
        mlock = 1'b0;
        check1(tag, avail_o, 1'b1);
    endtask

    // One operation: drive at a falling edge, check the pop data before the
    // rising edge, update the model at it, and check the status afterwards.
    task automatic op(input string tag, input logic psh, input logic pp, input logic [15:0] d);
        push_i = psh;
        pop_i = pp;
        push_data_i = d;
        #1;
        if (pp) check16(tag, pop_data_o, exp_top());
        @(posedge clk);
        if (psh && !pp) begin
            mmem[mptr] = d;
            if (mptr == 4'hF) mlock = 1'b1;
            mptr = mptr + 4'd1;
        end else if (pp && !psh) begin
            mptr = mptr - 4'd1;
        end else if (psh && pp) begin
            mmem[4'(mptr - 4'd1)] = d;
        end
        @(negedge clk);
        push_i = 1'b0;
        pop_i = 1'b0;
        check1(tag, avail_o, exp_avail());
    endtask

    initial begin : watchdog
        #2_000_000;
        bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        int seed;
        seed = $urandom(32'd20240611);
        @(negedge clk);

        // R1 reset state, R6 pop after reset and no lock on a downward wrap
        do_reset("R1 reset avail");
        op("R1 pop after reset reads zero", 1'b0, 1'b1, 16'h0);
        check1("R6 avail low after underflow pop", avail_o, 1'b0);
        op("R6 second pop frees flag", 1'b0, 1'b1, 16'h0);
        check1("R6 no lock from pop wrap", avail_o, 1'b1);

        // R2 last-in first-out ordering
        do_reset("R2 reset");
        op("R2 push", 1'b1, 1'b0, 16'hA001);
        op("R2 push", 1'b1, 1'b0, 16'hA002);
        op("R2 push", 1'b1, 1'b0, 16'hA003);
        op("R2 pop third", 1'b0, 1'b1, 16'h0);
        op("R2 pop second", 1'b0, 1'b1, 16'h0);
        check16("R2 literal first", pop_data_o, 16'hA001);
        op("R2 pop first", 1'b0, 1'b1, 16'h0);

        // R3 status on the last slot, R4 lock on the upward wrap
        do_reset("R3 reset");
        for (int i = 0; i < 14; i++) op("R3 fill", 1'b1, 1'b0, 16'(16'hB000 + i));
        check1("R3 avail after 14 pushes", avail_o, 1'b1);
        op("R3 fifteenth push", 1'b1, 1'b0, 16'hB00E);
        check1("R3 avail after 15 pushes", avail_o, 1'b0);
        op("R4 wrapping push", 1'b1, 1'b0, 16'hB00F);
        for (int i = 0; i < 4; i++) op("R4 lock holds on pop", 1'b0, 1'b1, 16'h0);
        op("R4 lock holds on push", 1'b1, 1'b0, 16'hB0FF);
        check1("R4 literal locked", avail_o, 1'b0);

        // R5 overflow overwrite order
        do_reset("R5 reset");
        for (int i = 0; i < 17; i++) op("R5 push", 1'b1, 1'b0, 16'(16'hC000 + i));
        #1;
        check16("R5 first pop is d16", pop_data_o, 16'hC010);
        for (int i = 0; i < 16; i++) op("R5 pop order", 1'b0, 1'b1, 16'h0);
        #1;
        check16("R5 seventeenth pop is d16 again", pop_data_o, 16'hC010);
        op("R5 seventeenth pop", 1'b0, 1'b1, 16'h0);

        // R6 underflow then push locks
        do_reset("R6 reset");
        op("R6 underflow pop", 1'b0, 1'b1, 16'h0);
        op("R6 push after underflow", 1'b1, 1'b0, 16'hD001);
        op("R6 pop after lock", 1'b0, 1'b1, 16'h0);
        op("R6 pop after lock", 1'b0, 1'b1, 16'h0);
        check1("R6 locked after underflow push", avail_o, 1'b0);

        // R7 simultaneous push and pop replaces the top
        do_reset("R7 reset");
        op("R7 push", 1'b1, 1'b0, 16'hE001);
        op("R7 push", 1'b1, 1'b0, 16'hE002);
        op("R7 swap shows old top", 1'b1, 1'b1, 16'hE0CC);
        #1;
        check16("R7 top replaced", pop_data_o, 16'hE0CC);
        op("R7 pop replaced", 1'b0, 1'b1, 16'h0);
        #1;
        check16("R7 pointer unchanged", pop_data_o, 16'hE001);
        op("R7 pop below", 1'b0, 1'b1, 16'h0);

        // R8 swap on the last slot does not lock
        do_reset("R8 reset");
        for (int i = 0; i < 15; i++) op("R8 fill", 1'b1, 1'b0, 16'(16'hF000 + i));
        op("R8 swap at last slot", 1'b1, 1'b1, 16'hF0AA);
        check1("R8 still low at last slot", avail_o, 1'b0);
        op("R8 pop releases", 1'b0, 1'b1, 16'h0);
        check1("R8 no lock from swap", avail_o, 1'b1);

        // R2 random traffic against the model
        do_reset("R2 random reset");
        for (int i = 0; i < 400; i++) begin
            logic [1:0] k;
            k = 2'($urandom_range(0, 3));
            op("R2 random", k[0], k[1], 16'($urandom));
        end

        // R9 reset recovery after a lock
        do_reset("R9 reset");
        for (int i = 0; i < 16; i++) op("R9 lock up", 1'b1, 1'b0, 16'(i));
        do_reset("R9 reset after lock");
        op("R9 pop reads zero", 1'b0, 1'b1, 16'h0);
        op("R9 push back", 1'b1, 1'b0, 16'h9000);
        do_reset("R9 second reset");
        for (int i = 0; i < 15; i++) op("R9 refill", 1'b1, 1'b0, 16'(16'h9100 + i));
        check1("R9 low at last slot", avail_o, 1'b0);
        op("R9 pop frees", 1'b0, 1'b1, 16'h0);
        check1("R9 recovered", avail_o, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule